// File: doc/BRIEF.md
# Dual-Bank Context Store

This block holds context streams (one instruction word per step) for an array of identical SIMD cells. It has two banks. At any time one bank is *active* and the other is the *load* bank. The sequencer reads contexts out of the active bank. Each context read is driven onto one shared word and copied to every cell in the same cycle. While that happens, a DMA write port fills the load bank with the next task's stream.

A DMA beat flagged as last marks the load bank as ready. Once the running stream has finished, a swap request exchanges the roles of the two banks. The next start then runs the fresh stream from address 0 with no reload gap.

The length of a stream comes from a length register. That value is captured when a stream starts and is clamped to the bank depth. Each step request moves the stream forward by one context. The output valid drops once the captured number of contexts has been stepped through.

Top module: `ctx_pingpong`

## Requirements
- R1: After reset, bank 0 is active, both ready flags (`ready_o[0]` for bank 0, `ready_o[1]` for bank 1) are 0, and `busy_o`, `ctx_valid_o` and `dma_err_o` are all 0.
- R2: A DMA beat whose target bank is not the active bank stores its data at the given address. If that beat also carries the last flag, the target bank's ready flag is 1 after the same clock edge, unless a swap is honoured at that edge.
- R3: A DMA beat aimed at the active bank changes no stored word. It raises `dma_err_o` for exactly the one cycle after that edge. `dma_err_o` is 0 after every other edge.
- R4: A swap request is honoured only when the block is idle and the load bank's ready flag is 1. An honoured swap flips `active_o` and clears both ready flags at that edge. A swap request that does not meet these conditions changes nothing.
- R5: A start request with a non-zero length captured from the length register has the following effect at the next edge: `busy_o` and `ctx_valid_o` rise and `ctx_o` carries word 0 of the active bank. Each step moves the output to the next address. After as many steps as the captured length, `ctx_valid_o` is 0.
- R6: Every one of the CELLS slices of `ctx_o` (slice c at bits c*CTX_W upward) carries the same context in the same cycle.
- R7: A start request is ignored while a stream runs or when the length register holds 0. A step request while idle has no effect.
- R8: DMA writes into the load bank during a running stream do not disturb the stream that is being read out.
- R9: A swap request while a stream runs leaves `active_o` and the output stream unchanged.
- R10: A length above DEPTH runs exactly DEPTH contexts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dma_valid_i | input | 1 | DMA beat present |
| dma_bank_i | input | 1 | Target bank of the beat |
| dma_addr_i | input | AW | Word address inside the bank |
| dma_data_i | input | CTX_W | Context word to store |
| dma_last_i | input | 1 | Final beat of a stream; marks the bank ready |
| dma_err_o | output | 1 | One-cycle pulse: a beat aimed at the active bank was rejected |
| len_we_i | input | 1 | Load the stream-length register |
| len_i | input | LW | New stream length |
| start_i | input | 1 | Begin streaming the active bank from address 0 |
| step_i | input | 1 | Advance to the next context |
| swap_i | input | 1 | Request a bank exchange |
| active_o | output | 1 | Index of the executing bank |
| ready_o | output | 2 | Per-bank loaded-and-waiting flags |
| busy_o | output | 1 | A stream is running |
| ctx_valid_o | output | 1 | `ctx_o` holds a live context |
| ctx_o | output | CELLS*CTX_W | Context word copied to every cell |

## Verification
Every state result of this block becomes visible at the first clock edge after its stimulus. This applies to the error pulse, the ready flags, the active bank, and the busy and valid levels. The bench drives inputs one nanosecond after a rising edge and reads these results right after the next rising edge. The context on `ctx_o` is read combinationally from the stored pointer, so it belongs to the cycle in which the step that consumes it is applied. The monitor therefore compares that context at the falling edge of the same cycle, against a queue that the driver filled from its own model of both banks. A restart or a disturbed stream would leave that queue out of order or not empty.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  typedef enum logic {
    BANK0 = 1'b0,
    BANK1 = 1'b1
  } bank_e;

  typedef struct packed {
    logic  valid;
    bank_e bank;
    logic  last;
  } dma_ctl_t;

  function automatic bank_e bank_other(bank_e b);
    return (b == BANK0) ? BANK1 : BANK0;
  endfunction
endpackage

// File: rtl/ctx_bank.sv
module ctx_bank #(
  parameter int CTX_W = 16,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [CTX_W-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [CTX_W-1:0] rdata_o
);
  logic [CTX_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ctx_bank_ctrl.sv
module ctx_bank_ctrl
  import ctx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  dma_ctl_t   dma_i,
  input  logic       swap_i,
  input  logic       busy_i,
  output logic [1:0] we_o,
  output logic       active_o,
  output logic [1:0] ready_o,
  output logic       err_o
);
  bank_e      active_q;
  logic [1:0] ready_q;
  logic       err_q;
  logic       hit_active, accept, swap_ok;
  bank_e      other;

  assign other      = bank_other(active_q);
  assign hit_active = dma_i.valid && (dma_i.bank == active_q);
  assign accept     = dma_i.valid && (dma_i.bank != active_q);
  assign swap_ok    = swap_i && !busy_i && ready_q[other];

  always_comb begin
    we_o = 2'b00;
    if (accept) we_o[dma_i.bank] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= BANK0;
      ready_q  <= 2'b00;
      err_q    <= 1'b0;
    end else begin
      err_q <= hit_active;
      if (swap_ok) begin
        // swap wins over a same-cycle last beat
        active_q <= other;
        ready_q  <= 2'b00;
      end else if (accept && dma_i.last) begin
        ready_q[dma_i.bank] <= 1'b1;
      end
    end
  end

  assign active_o = active_q;
  assign ready_o  = ready_q;
  assign err_o    = err_q;
endmodule

// File: rtl/ctx_seq.sv
module ctx_seq #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          len_we_i,
  input  logic [LW-1:0] len_i,
  input  logic          start_i,
  input  logic          step_i,
  output logic          busy_o,
  output logic [AW-1:0] ptr_o
);
  localparam logic [LW-1:0] MaxLen = LW'(DEPTH);

  logic [LW-1:0] len_q, run_q;
  logic [AW-1:0] ptr_q;
  logic          busy_q;
  logic          start_ok, adv, at_end;

  assign start_ok = start_i && !busy_q && (len_q != '0);
  assign adv      = busy_q && step_i;
  assign at_end   = (LW'(ptr_q) + LW'(1)) == run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= '0;
      run_q  <= '0;
      ptr_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      if (len_we_i) len_q <= len_i;
      if (start_ok) begin
        busy_q <= 1'b1;
        ptr_q  <= '0;
        run_q  <= (len_q > MaxLen) ? MaxLen : len_q;
      end else if (adv) begin
        if (at_end) begin
          busy_q <= 1'b0;
          ptr_q  <= '0;
        end else begin
          ptr_q <= ptr_q + AW'(1);
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign ptr_o  = ptr_q;
endmodule

// File: rtl/ctx_pingpong.sv
module ctx_pingpong
  import ctx_pkg::*;
#(
  parameter int CTX_W = 16,
  parameter int DEPTH = 16,
  parameter int CELLS = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   dma_valid_i,
  input  logic                   dma_bank_i,
  input  logic [AW-1:0]          dma_addr_i,
  input  logic [CTX_W-1:0]       dma_data_i,
  input  logic                   dma_last_i,
  output logic                   dma_err_o,
  input  logic                   len_we_i,
  input  logic [LW-1:0]          len_i,
  input  logic                   start_i,
  input  logic                   step_i,
  input  logic                   swap_i,
  output logic                   active_o,
  output logic [1:0]             ready_o,
  output logic                   busy_o,
  output logic                   ctx_valid_o,
  output logic [CELLS*CTX_W-1:0] ctx_o
);
  dma_ctl_t         dma_ctl;
  logic [1:0]       bank_we;
  logic [AW-1:0]    ptr;
  logic             busy;
  logic             active;
  logic [CTX_W-1:0] rdata [2];
  logic [CTX_W-1:0] ctx_word;

  assign dma_ctl = '{valid: dma_valid_i, bank: bank_e'(dma_bank_i), last: dma_last_i};

  ctx_bank_ctrl i_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .dma_i    (dma_ctl),
    .swap_i   (swap_i),
    .busy_i   (busy),
    .we_o     (bank_we),
    .active_o (active),
    .ready_o  (ready_o),
    .err_o    (dma_err_o)
  );

  ctx_seq #(.DEPTH(DEPTH)) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .len_we_i (len_we_i),
    .len_i    (len_i),
    .start_i  (start_i),
    .step_i   (step_i),
    .busy_o   (busy),
    .ptr_o    (ptr)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    ctx_bank #(.CTX_W(CTX_W), .DEPTH(DEPTH)) i_bank (
      .clk_i   (clk_i),
      .we_i    (bank_we[b]),
      .waddr_i (dma_addr_i),
      .wdata_i (dma_data_i),
      .raddr_i (ptr),
      .rdata_o (rdata[b])
    );
  end

  assign ctx_word = busy ? rdata[active] : '0;

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    assign ctx_o[c*CTX_W +: CTX_W] = ctx_word;
  end

  assign active_o    = active;
  assign busy_o      = busy;
  assign ctx_valid_o = busy;
endmodule

// File: rtl/ctx_pingpong_chk.sv
module ctx_pingpong_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       dma_valid_i,
  input logic       dma_bank_i,
  input logic       dma_last_i,
  input logic       dma_err_o,
  input logic       start_i,
  input logic       swap_i,
  input logic       active_o,
  input logic [1:0] ready_o,
  input logic       busy_o
);
  a_r3_reject_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_valid_i && (dma_bank_i == active_o) |=> dma_err_o);

  a_r3_quiet_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dma_valid_i && (dma_bank_i == active_o)) |=> !dma_err_o);

  a_r2_last_sets_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_valid_i && dma_last_i && (dma_bank_i != active_o) && !swap_i
    |=> ready_o[$past(dma_bank_i)]);

  a_r4_swap_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_i && !busy_o && ready_o[~active_o]
    |=> (ready_o == 2'b00) && (active_o != $past(active_o)));

  a_r9_hold_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(active_o));

  a_r7_idle_stays_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> !busy_o);
endmodule

bind ctx_pingpong ctx_pingpong_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dma_valid_i (dma_valid_i),
  .dma_bank_i  (dma_bank_i),
  .dma_last_i  (dma_last_i),
  .dma_err_o   (dma_err_o),
  .start_i     (start_i),
  .swap_i      (swap_i),
  .active_o    (active_o),
  .ready_o     (ready_o),
  .busy_o      (busy_o)
);

// File: tb/test_ctx_pingpong.sv
`timescale 1ns/1ps
module test_ctx_pingpong;
  localparam int CTX_W = 16;
  localparam int DEPTH = 16;
  localparam int CELLS = 64;
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic dma_valid_i = 1'b0, dma_bank_i = 1'b0, dma_last_i = 1'b0;
  logic [AW-1:0] dma_addr_i = '0;
  logic [CTX_W-1:0] dma_data_i = '0;
  logic len_we_i = 1'b0, start_i = 1'b0, step_i = 1'b0, swap_i = 1'b0;
  logic [LW-1:0] len_i = '0;
  logic dma_err_o, active_o, busy_o, ctx_valid_o;
  logic [1:0] ready_o;
  logic [CELLS*CTX_W-1:0] ctx_o;

  always #4 clk_i = ~clk_i;

  ctx_pingpong #(.CTX_W(CTX_W), .DEPTH(DEPTH), .CELLS(CELLS)) i_ctx_pingpong (.*);

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;
  logic [CTX_W-1:0] exp_q [$];
  logic [CTX_W-1:0] mem_m [2][DEPTH];
  logic act_m = 1'b0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // monitor: a context is consumed when a step is applied while valid
  always @(negedge clk_i) begin
    if (rst_ni && ctx_valid_o && step_i) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5 unexpected context", longint'(ctx_o[CTX_W-1:0]), 0);
      end else begin
        logic [CTX_W-1:0] e;
        bit same;
        e = exp_q.pop_front();
        same = 1'b1;
        for (int c = 0; c < CELLS; c++)
          if (ctx_o[c*CTX_W +: CTX_W] != e) same = 1'b0;
        check(same, "R5 R6 R8 context", longint'(ctx_o[CTX_W-1:0]), longint'(e));
      end
    end
  end

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  function automatic logic [CTX_W-1:0] pat(input int bank, input int addr, input int seed);
    return CTX_W'(16'h3c00 ^ (bank << 12) ^ (seed << 5) ^ (addr * 7 + 1));
  endfunction

  task automatic dma(input logic bank, input int addr, input logic [CTX_W-1:0] d, input logic last);
    dma_valid_i = 1'b1; dma_bank_i = bank; dma_addr_i = AW'(addr);
    dma_data_i = d; dma_last_i = last;
    if (bank != act_m) mem_m[bank][addr] = d;
    tick();
    dma_valid_i = 1'b0; dma_last_i = 1'b0;
  endtask

  task automatic set_len(input int n);
    len_we_i = 1'b1; len_i = LW'(n);
    tick();
    len_we_i = 1'b0;
  endtask

  task automatic push_expect(input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(mem_m[act_m][i]);
  endtask

  task automatic stream(input int len, input int n);
    set_len(len);
    push_expect(n);
    start_i = 1'b1; tick(); start_i = 1'b0;
    check(ctx_valid_o == 1'b1, "R5 valid after start", longint'(ctx_valid_o), 1);
    for (int i = 0; i < n; i++) begin
      step_i = 1'b1; tick(); step_i = 1'b0;
    end
    check(ctx_valid_o == 1'b0, "R5 R10 valid drops at length", longint'(ctx_valid_o), 0);
    check(exp_q.size() == 0, "R5 R10 all contexts seen", longint'(exp_q.size()), 0);
  endtask

  task automatic do_swap();
    swap_i = 1'b1; tick(); swap_i = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    #20 rst_ni = 1'b1;
    tick();
    // R1 reset state
    check(active_o == 1'b0 && ready_o == 2'b00, "R1 active/ready",
          longint'({active_o, ready_o}), 0);
    check(!busy_o && !ctx_valid_o && !dma_err_o, "R1 busy/valid/err",
          longint'({busy_o, ctx_valid_o, dma_err_o}), 0);

    // R7 step while idle, start with zero length
    step_i = 1'b1; tick(); step_i = 1'b0;
    check(busy_o == 1'b0, "R7 idle step", longint'(busy_o), 0);
    start_i = 1'b1; tick(); start_i = 1'b0;
    check(busy_o == 1'b0, "R7 zero length start", longint'(busy_o), 0);

    // R4 swap with nothing ready
    do_swap();
    check(active_o == 1'b0, "R4 swap without ready ignored", longint'(active_o), 0);

    // R3 write into active bank
    dma(1'b0, 0, 16'hdead, 1'b1);
    check(dma_err_o == 1'b1 && ready_o == 2'b00, "R3 reject pulse",
          longint'({dma_err_o, ready_o}), 4);
    tick();
    check(dma_err_o == 1'b0, "R3 pulse one cycle", longint'(dma_err_o), 0);

    // R2 load bank 1
    for (int i = 0; i < DEPTH; i++) begin
      dma(1'b1, i, pat(1, i, 0), i == DEPTH - 1);
      if (i == DEPTH - 2)
        check(ready_o == 2'b00, "R2 not ready before last", longint'(ready_o), 0);
    end
    check(ready_o == 2'b10 && dma_err_o == 1'b0, "R2 ready after last",
          longint'({dma_err_o, ready_o}), 2);

    do_swap(); act_m = 1'b1;
    check(active_o == 1'b1 && ready_o == 2'b00, "R4 swap honoured",
          longint'({active_o, ready_o}), 4);

    stream(5, 5);

    // R8 R9 R7 overlapped load, swap and start attempts while busy
    set_len(DEPTH);
    push_expect(DEPTH);
    start_i = 1'b1; tick(); start_i = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      step_i = 1'b1;
      dma_valid_i = 1'b1; dma_bank_i = 1'b0; dma_addr_i = AW'(i);
      dma_data_i = pat(0, i, 1); dma_last_i = (i == 11);
      mem_m[0][i] = pat(0, i, 1);
      if (i == 5) start_i = 1'b1;
      if (i == 13) swap_i = 1'b1;
      tick();
      step_i = 1'b0; dma_valid_i = 1'b0; dma_last_i = 1'b0;
      start_i = 1'b0; swap_i = 1'b0;
      if (i == 13)
        check(active_o == 1'b1, "R9 swap while busy ignored", longint'(active_o), 1);
    end
    check(ctx_valid_o == 1'b0 && exp_q.size() == 0, "R7 R8 overlapped stream complete",
          longint'(exp_q.size()), 0);
    check(ready_o == 2'b01, "R2 load bank ready", longint'(ready_o), 1);

    do_swap(); act_m = 1'b0;
    check(active_o == 1'b0 && ready_o == 2'b00, "R4 swap back",
          longint'({active_o, ready_o}), 0);

    // R10 clamp
    stream(20, DEPTH);

    // R3 rejected write leaves data intact
    dma(1'b0, 2, 16'hbeef, 1'b0);
    check(dma_err_o == 1'b1, "R3 reject idle active bank", longint'(dma_err_o), 1);
    stream(3, 3);

    tick();
    summary();
  end
endmodule